// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block keeps the receive-side status of an asynchronous serial channel. It sits between the bit-level receiver, which hands over one finished byte at a time with its parity and framing verdicts, and the status register that a CPU reads. It holds the received byte in a data register and keeps four flags: receive-full, overrun, parity error and framing error. A byte that arrives with an error is still delivered, and it still sets receive-full.

Receive-full drops when the CPU reads the data register. The three error flags are sticky. They clear only when software writes 0 to the error-flag-clear control bit. A carrier-detect input held high, or the global I/O stop mode, forces all four flags clear and makes the block ignore arriving bytes. The block also packs an 8-bit status word that carries three software-writable enable bits and a transmit-empty bit taken from the transmitter. It raises a receive interrupt request when that request is enabled and any receive flag is set.

The byte input is a valid-only stream with no back-pressure. The block accepts every presented byte in the cycle it is offered. When the data register is still full and unread, the new byte is dropped and overrun is raised. No ready signal exists, so the receiver never stalls.

Top module: `rx_status_flags`

## Requirements
- R1: After reset, receive-full, overrun, parity error and framing error are 0, the three writable status bits are 0, and the status word is 0 while `tx_empty` is 0.
- R2: The status word holds, from bit 7 down to bit 0: receive-full, overrun, parity error, framing error, receive interrupt enable, CTS enable, `tx_empty`, transmit interrupt enable.
- R3: A byte offered while receive-full is 0 is loaded into the data register, and receive-full reads 1 from the next cycle on. This holds also when the byte carries a parity or framing error.
- R4: A read strobe with no new byte clears receive-full at the next edge. A read strobe and a new byte in the same cycle load the new byte, and receive-full stays 1.
- R5: A byte offered while receive-full is 1 and no read strobe is present sets overrun. The data register keeps the earlier byte and the new byte is discarded.
- R6: Parity error is set by a loaded byte only when that byte has a parity error and `par_check_en` is 1. Framing error is set by any loaded byte that has a framing error.
- R7: Overrun, parity error and framing error stay set across data-register reads. They clear at the edge after `efr_wr` is pulsed with `efr_wdata` = 0. A pulse with `efr_wdata` = 1 leaves them unchanged.
- R8: While `carrier_hi` or `io_stop` is 1, all four flags clear at the next edge and stay 0, and offered bytes are ignored: the data register keeps its value.
- R9: A `stat_wr` pulse loads bits 3, 2 and 0 of `stat_wdata` into the receive interrupt enable, CTS enable and transmit interrupt enable bits. The other bits of `stat_wdata` have no effect.
- R10: `rx_irq` is 1 exactly when the receive interrupt enable is 1 and at least one of the four receive flags is 1.
- R11: When a new error and an error-clear write occur in the same cycle, the newly detected error is set and the other error flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Receiver presents a completed byte this cycle |
| byte_data | input | DATA_W | Completed byte |
| byte_par_err | input | 1 | Parity check failed for the presented byte |
| byte_frm_err | input | 1 | Stop bit missing for the presented byte |
| par_check_en | input | 1 | Parity checking enabled by the mode setting |
| rdr_read | input | 1 | CPU read strobe of the data register |
| efr_wr | input | 1 | Write strobe of the error-flag-clear control bit |
| efr_wdata | input | 1 | Value written to the error-flag-clear bit; 0 clears |
| carrier_hi | input | 1 | Carrier-detect input; high forces the flags clear |
| io_stop | input | 1 | Global I/O stop mode |
| stat_wr | input | 1 | Write strobe of the status word's writable bits |
| stat_wdata | input | 8 | Write data for the status word |
| tx_empty | input | 1 | Transmit-empty indication from the transmitter |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| rdr_data | output | DATA_W | Data register contents |
| status_word | output | 8 | Packed status word |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Every flag and the data register change at the first clock edge after the cycle in which their stimulus is presented. `rx_irq`, the status word's packing and its `tx_empty` bit follow those registers with no extra delay. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It therefore samples results half a cycle after the one rising edge that acts on them. Tests for stickiness and for ignored input check the outputs again after further idle cycles, so a late change would also show.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_RDF  = 7;
  localparam int BIT_OVR  = 6;
  localparam int BIT_PAR  = 5;
  localparam int BIT_FRM  = 4;
  localparam int BIT_RIE  = 3;
  localparam int BIT_CTSE = 2;
  localparam int BIT_TDE  = 1;
  localparam int BIT_TIE  = 0;

  localparam int N_ERR   = 3;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;

  typedef struct packed {
    logic rie;
    logic ctse;
    logic tie;
  } ctl_bits_t;
endpackage

// File: rtl/rxs_hold.sv
module rxs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              rd_strobe,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              load,
  output logic              lost
);
  logic accept;

  assign accept = byte_valid & ~flush;
  assign load   = accept & (~full | rd_strobe);
  assign lost   = accept & full & ~rd_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (load) data <= byte_data;
      if (flush)          full <= 1'b0;
      else if (load)      full <= 1'b1;
      else if (rd_strobe) full <= 1'b0;
    end
  end

  AST_FULL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> full); // R3
  AST_KEEP_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (full && $stable(data))); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!full && $stable(data))); // R8
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !byte_valid && !flush) |=> !full); // R4
endmodule

// File: rtl/rxs_errflags.sv
module rxs_errflags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] set_vec,
  input  logic         clr_req,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (flush)      flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_req)    flags[i] <= 1'b0;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !flush && !clr_req) |=> flags[i]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[i] && !flush) |=> flags[i]); // R11
    AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_vec[i]) |=> !flags[i]); // R7
  end
endmodule

// File: rtl/rxs_ctlbits.sv
module rxs_ctlbits
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  output ctl_bits_t         ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr) begin
      ctl.rie  <= wdata[BIT_RIE];
      ctl.ctse <= wdata[BIT_CTSE];
      ctl.tie  <= wdata[BIT_TIE];
    end
  end

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctl)); // R9
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_par_err,
  input  logic              byte_frm_err,
  input  logic              par_check_en,
  input  logic              rdr_read,
  input  logic              efr_wr,
  input  logic              efr_wdata,
  input  logic              carrier_hi,
  input  logic              io_stop,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  output logic              par_err,
  output logic              frm_err,
  output logic [DATA_W-1:0] rdr_data,
  output logic [7:0]        status_word,
  output logic              rx_irq
);
  logic             flush;
  logic             load;
  logic             lost;
  logic             clr_req;
  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_q;
  ctl_bits_t        ctl;

  assign flush   = carrier_hi | io_stop;
  assign clr_req = efr_wr & ~efr_wdata;

  rxs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .rd_strobe  (rdr_read),
    .full       (rx_full),
    .data       (rdr_data),
    .load       (load),
    .lost       (lost)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = lost;
    err_set[ERR_PAR] = load & byte_par_err & par_check_en;
    err_set[ERR_FRM] = load & byte_frm_err;
  end

  rxs_errflags #(.N(N_ERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .set_vec (err_set),
    .clr_req (clr_req),
    .flags   (err_q)
  );

  rxs_ctlbits u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (stat_wr),
    .wdata (stat_wdata),
    .ctl   (ctl)
  );

  assign overrun = err_q[ERR_OVR];
  assign par_err = err_q[ERR_PAR];
  assign frm_err = err_q[ERR_FRM];

  always_comb begin
    status_word           = '0;
    status_word[BIT_RDF]  = rx_full;
    status_word[BIT_OVR]  = overrun;
    status_word[BIT_PAR]  = par_err;
    status_word[BIT_FRM]  = frm_err;
    status_word[BIT_RIE]  = ctl.rie;
    status_word[BIT_CTSE] = ctl.ctse;
    status_word[BIT_TDE]  = tx_empty;
    status_word[BIT_TIE]  = ctl.tie;
  end

  assign rx_irq = ctl.rie & (rx_full | overrun | par_err | frm_err);

  AST_NO_PAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_check_en && !par_err) |=> !par_err); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (status_word[7:4] != 4'b0)); // R10
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (status_word[7:4] == 4'b0)); // R8
endmodule

// File: tb/rx_status_flags_bench.sv
module rx_status_flags_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_valid, byte_par_err, byte_frm_err, par_check_en;
  logic [7:0] byte_data;
  logic       rdr_read, efr_wr, efr_wdata, carrier_hi, io_stop;
  logic       stat_wr, tx_empty;
  logic [7:0] stat_wdata;
  logic       rx_full, overrun, par_err, frm_err, rx_irq;
  logic [7:0] rdr_data, status_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_status_flags #(.DATA_W(8)) u_rx_status_flags (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_par_err(byte_par_err), .byte_frm_err(byte_frm_err),
    .par_check_en(par_check_en), .rdr_read(rdr_read), .efr_wr(efr_wr),
    .efr_wdata(efr_wdata), .carrier_hi(carrier_hi), .io_stop(io_stop),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .par_err(par_err), .frm_err(frm_err),
    .rdr_data(rdr_data), .status_word(status_word), .rx_irq(rx_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    byte_valid = 0; byte_data = 8'h00; byte_par_err = 0; byte_frm_err = 0;
    rdr_read = 0; efr_wr = 0; efr_wdata = 1; stat_wr = 0; stat_wdata = 8'h00;
  endtask

  // pulses set at a falling edge are removed at the next falling edge
  task automatic step();
    @(negedge clk);
    idle_in();
  endtask

  task automatic send(logic [7:0] d, logic pe, logic fe);
    @(negedge clk);
    byte_valid = 1; byte_data = d; byte_par_err = pe; byte_frm_err = fe;
    step();
  endtask

  task automatic rd();
    @(negedge clk); rdr_read = 1; step();
  endtask

  task automatic efr(logic v);
    @(negedge clk); efr_wr = 1; efr_wdata = v; step();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 full", rx_full, 0);
    chk("R1 flags", {overrun, par_err, frm_err}, 0);
    chk("R1 word", status_word, 8'h00);
    chk("R1 irq", rx_irq, 0);
  endtask

  task automatic t_load_read();
    send(8'h5A, 0, 0);
    chk("R3 full", rx_full, 1);
    chk("R3 data", rdr_data, 8'h5A);
    rd();
    chk("R4 read clears", rx_full, 0);
    chk("R4 data kept", rdr_data, 8'h5A);
  endtask

  task automatic t_err_byte();
    send(8'hC3, 0, 1);
    chk("R3 err byte full", rx_full, 1);
    chk("R3 err byte data", rdr_data, 8'hC3);
    chk("R6 frm set", frm_err, 1);
    rd();
    chk("R7 frm survives read", frm_err, 1);
    efr(1);
    chk("R7 write 1 no effect", frm_err, 1);
    efr(0);
    chk("R7 write 0 clears", frm_err, 0);
  endtask

  task automatic t_overrun();
    send(8'h11, 0, 0);
    send(8'h22, 1, 1);
    chk("R5 ovr set", overrun, 1);
    chk("R5 data kept", rdr_data, 8'h11);
    chk("R5 full", rx_full, 1);
    chk("R6 no err from dropped", {par_err, frm_err}, 0);
    rd();
    chk("R7 ovr sticky", overrun, 1);
    efr(0);
    chk("R7 ovr clear", overrun, 0);
  endtask

  task automatic t_read_and_load();
    send(8'h33, 0, 0);
    @(negedge clk);
    rdr_read = 1; byte_valid = 1; byte_data = 8'h44;
    step();
    chk("R4 same cycle full", rx_full, 1);
    chk("R4 same cycle data", rdr_data, 8'h44);
    chk("R4 no overrun", overrun, 0);
    rd();
  endtask

  task automatic t_parity_gate();
    par_check_en = 0;
    send(8'h01, 1, 0);
    chk("R6 par off", par_err, 0);
    rd();
    par_check_en = 1;
    send(8'h02, 1, 0);
    chk("R6 par on", par_err, 1);
    rd();
    efr(0);
  endtask

  task automatic t_stop(bit use_carrier, string req);
    send(8'h77, 0, 1);
    send(8'h88, 0, 0);
    @(negedge clk);
    if (use_carrier) carrier_hi = 1; else io_stop = 1;
    byte_valid = 1; byte_data = 8'h99;
    step();
    chk(req, {rx_full, overrun, par_err, frm_err}, 0);
    chk(req, rdr_data, 8'h77);
    byte_valid = 1; byte_data = 8'hAA;
    step(); step();
    chk(req, {rx_full, overrun, par_err, frm_err}, 0);
    chk(req, rdr_data, 8'h77);
    carrier_hi = 0; io_stop = 0;
    step();
  endtask

  task automatic t_ctl_and_word();
    @(negedge clk); stat_wr = 1; stat_wdata = 8'hFF; step();
    chk("R9 only rw bits", status_word, 8'h0D);
    @(negedge clk); stat_wr = 1; stat_wdata = 8'b1111_0111; step();
    chk("R9 rie cleared", status_word, 8'h05);
    @(negedge clk); stat_wr = 1; stat_wdata = 8'b0000_1000; step();
    tx_empty = 1;
    send(8'h10, 0, 1);
    chk("R2 packing", status_word, 8'h9A);
    chk("R10 irq on", rx_irq, 1);
    rd();
    chk("R10 irq from err", rx_irq, 1);
    efr(0);
    chk("R10 irq off", rx_irq, 0);
    tx_empty = 0;
  endtask

  task automatic t_set_wins();
    send(8'h20, 0, 1);
    rd();
    @(negedge clk);
    byte_valid = 1; byte_data = 8'h21; byte_par_err = 1;
    efr_wr = 1; efr_wdata = 0;
    step();
    chk("R11 new par set", par_err, 1);
    chk("R11 old frm cleared", frm_err, 0);
    rd(); efr(0);
  endtask

  initial begin
    rst_n = 0; carrier_hi = 0; io_stop = 0; tx_empty = 0; par_check_en = 1;
    idle_in();
    do_reset();
    t_reset();
    t_load_read();
    t_err_byte();
    t_overrun();
    t_read_and_load();
    t_parity_gate();
    t_stop(1'b1, "R8 carrier");
    rd(); efr(0);
    t_stop(1'b0, "R8 iostop");
    t_ctl_and_word();
    t_set_wins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule